// File: doc/BRIEF.md
# Bus Transaction Trace Recorder

This block sits beside a shared-memory bus and logs every transaction it sees into an on-chip record queue. Each record holds three things: the 32-bit physical address, whether the transfer was a write, and which agent issued it. The agent is one of four processors taking a cache miss, or the I/O system doing a DMA transfer. Each record also carries the number of clock cycles since the previous stored record, so the exact spacing of bus traffic can be rebuilt later. A compare-and-mask filter can drop chosen transactions before they take up storage.

Software empties the queue through a drain port. To avoid losing trace data, the block raises a halt interrupt to all processors when the queue occupancy reaches a programmable threshold. The interrupt stays raised until the queue is completely empty.

The snoop side has no back-pressure, because a bus monitor cannot stall the bus. A transaction is offered in any cycle where `snp_valid` is high, and it is either stored, filtered or lost in that same cycle. The drain side is valid/ready. `drn_valid` is high whenever the queue holds a record, and `drn_data` shows the oldest record. A record leaves the queue on a clock edge where both `drn_valid` and `drn_ready` are high. While `drn_valid` is high and `drn_ready` is low, `drn_data` holds steady.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset the queue is empty, `drn_valid` is low and `halt_irq` is low.
- R2: A record on `drn_data` is packed as follows, from most significant bit down:
  - the address in bits [DELTA_W+35:DELTA_W+4];
  - the write flag in bit DELTA_W+3;
  - the originator code in bits [DELTA_W+2:DELTA_W], where codes 0 to 3 name processors 0 to 3 and code 4 names the I/O system;
  - the cycle delta in bits [DELTA_W-1:0].
- R3: The cycle delta of a stored record equals the number of clock edges since the previous stored record. For the first record after reset it is the number of edges since reset was released, where a transaction at the first edge records 0.
- R4: The cycle delta saturates at 2^DELTA_W-1 and does not wrap.
- R5: When `cfg_filter_en` is high, a transaction is dropped and not stored if ({address, write, originator} XOR `cfg_match`) AND `cfg_mask` is zero. The attribute vector has the address in bits 35:4, the write flag in bit 3 and the originator in bits 2:0.
- R6: With `cfg_restart` high, a dropped transaction restarts the cycle delta, so the next stored record measures from the dropped transaction. With `cfg_restart` low, dropped transactions leave the delta untouched.
- R7: Records drain in arrival order under the valid/ready rules above.
- R8: A transaction that arrives while the queue holds DEPTH records is lost, even if a record drains at the same edge. A lost transaction does not restart the delta.
- R9: `halt_irq` rises at the edge on which the occupancy becomes non-zero and at least `cfg_halt_thr`.
- R10: Once raised, `halt_irq` stays high until the occupancy reaches zero, and it falls at the edge where the last record drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Bus transaction present this cycle |
| snp_addr | input | 32 | Physical address of the transaction |
| snp_write | input | 1 | 1 = write, 0 = read |
| snp_src | input | 3 | Originator code (0-3 processor, 4 I/O) |
| cfg_filter_en | input | 1 | Enables the drop filter |
| cfg_match | input | 36 | Attribute pattern to drop |
| cfg_mask | input | 36 | Attribute bits that take part in the compare |
| cfg_restart | input | 1 | Dropped transactions restart the cycle delta |
| cfg_halt_thr | input | $clog2(DEPTH)+1 | Occupancy at which the halt interrupt rises |
| drn_valid | output | 1 | Queue holds a record |
| drn_ready | input | 1 | Consumer takes the head record |
| drn_data | output | DELTA_W+36 | Head record |
| halt_irq | output | 1 | Halt interrupt to all processors |

## Verification
The assertions check these rules on every cycle:
- the occupancy never exceeds DEPTH and a full queue stays full unless it drains;
- a stalled head record holds steady;
- the delta holds once it reaches its maximum;
- a dropped transaction never raises the occupancy;
- the halt interrupt holds until the queue is empty, and it is always high while the occupancy is at or above a steady threshold.

Only the bench scenarios show the rest, by comparison with a cycle model. That covers the exact delta values across gaps, filter restarts and saturation, the packing of each originator into a record, the loss of transactions at a full queue, and the drain order of records across back-pressure and simultaneous store and drain.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int ADDR_W = 32;
  localparam int SRC_W  = 3;
  localparam int ATTR_W = ADDR_W + 1 + SRC_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_CPU0 = 3'd0,
    SRC_CPU1 = 3'd1,
    SRC_CPU2 = 3'd2,
    SRC_CPU3 = 3'd3,
    SRC_IO   = 3'd4
  } src_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [SRC_W-1:0]  src;
  } txn_attr_t;
endpackage

// File: rtl/trace_filter.sv
module trace_filter
  import trace_pkg::*;
(
  input  logic              en,
  input  logic [ATTR_W-1:0] attr,
  input  logic [ATTR_W-1:0] match,
  input  logic [ATTR_W-1:0] mask,
  output logic              drop
);
  logic [ATTR_W-1:0] diff;

  // A bit outside the mask never blocks a match.
  assign diff = (attr ^ match) & mask;
  assign drop = en && (diff == '0);
endmodule

// File: rtl/trace_delta.sv
module trace_delta #(
  parameter int DELTA_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stored,
  input  logic               restart,
  output logic [DELTA_W-1:0] gap
);
  localparam logic [DELTA_W-1:0] GAP_MAX = '1;

  logic [DELTA_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (stored || restart) begin
      gap_q <= DELTA_W'(1);
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + DELTA_W'(1);
    end
  end

  assign gap = gap_q;

  // R4
  delta_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == GAP_MAX && !stored && !restart) |=> (gap_q == GAP_MAX));
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 56,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             push_ok,
  output logic             dvalid,
  input  logic             dready,
  output logic [WIDTH-1:0] dout,
  output logic             pop,
  output logic [CNT_W-1:0] occ,
  output logic [CNT_W-1:0] occ_next
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ_q;

  assign push_ok = push && (occ_q != FULL);
  assign dvalid  = (occ_q != '0);
  assign pop     = dvalid && dready;
  assign dout    = mem[rd_ptr];

  always_comb begin
    occ_next = occ_q;
    if (push_ok && !pop)      occ_next = occ_q + CNT_W'(1);
    else if (!push_ok && pop) occ_next = occ_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      occ_q <= occ_next;
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop)     rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  assign occ = occ_q;

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL);

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == FULL && !dready) |=> (occ_q == FULL));

  // R7
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !dready) |=> (dvalid && $stable(dout)));
endmodule

// File: rtl/trace_halt.sv
module trace_halt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occ,
  input  logic [CNT_W-1:0] occ_next,
  input  logic [CNT_W-1:0] thr,
  output logic             halt
);
  logic halt_q;
  logic reach;

  assign reach = (occ_next != '0) && (occ_next >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n)      halt_q <= 1'b0;
    else if (halt_q) halt_q <= (occ_next != '0);
    else             halt_q <= reach;
  end

  assign halt = halt_q;

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q || occ == '0));

  // R9
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0 && occ >= thr && $stable(thr)) |-> halt_q);
endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
  import trace_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 20,
  localparam int CNT_W  = $clog2(DEPTH) + 1,
  localparam int REC_W  = ATTR_W + DELTA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [31:0]       snp_addr,
  input  logic              snp_write,
  input  logic [2:0]        snp_src,
  input  logic              cfg_filter_en,
  input  logic [35:0]       cfg_match,
  input  logic [35:0]       cfg_mask,
  input  logic              cfg_restart,
  input  logic [CNT_W-1:0]  cfg_halt_thr,
  output logic              drn_valid,
  input  logic              drn_ready,
  output logic [REC_W-1:0]  drn_data,
  output logic              halt_irq
);
  txn_attr_t          attr;
  logic               drop;
  logic               push_ok, pop;
  logic [DELTA_W-1:0] gap;
  logic [CNT_W-1:0]   occ, occ_next;

  assign attr = '{addr: snp_addr, wr: snp_write, src: snp_src};

  trace_filter u_filter (
    .en    (cfg_filter_en),
    .attr  (attr),
    .match (cfg_match),
    .mask  (cfg_mask),
    .drop  (drop)
  );

  trace_delta #(.DELTA_W(DELTA_W)) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .stored  (push_ok),
    .restart (snp_valid && drop && cfg_restart),
    .gap     (gap)
  );

  trace_fifo #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (snp_valid && !drop),
    .din      ({attr, gap}),
    .push_ok  (push_ok),
    .dvalid   (drn_valid),
    .dready   (drn_ready),
    .dout     (drn_data),
    .pop      (pop),
    .occ      (occ),
    .occ_next (occ_next)
  );

  trace_halt #(.CNT_W(CNT_W)) u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .occ      (occ),
    .occ_next (occ_next),
    .thr      (cfg_halt_thr),
    .halt     (halt_irq)
  );

  // R5
  drop_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && drop) |=> (occ <= $past(occ)));
endmodule

// File: tb/tb_bus_trace_capture.sv
module tb_bus_trace_capture;
  localparam int DEPTH   = 8;
  localparam int DELTA_W = 8;
  localparam int CNT_W   = $clog2(DEPTH) + 1;
  localparam int REC_W   = 36 + DELTA_W;
  localparam int GMAX    = (1 << DELTA_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic snp_write = 1'b0;
  logic [2:0] snp_src = '0;
  logic cfg_filter_en = 1'b0;
  logic [35:0] cfg_match = '0;
  logic [35:0] cfg_mask = '0;
  logic cfg_restart = 1'b0;
  logic [CNT_W-1:0] cfg_halt_thr = CNT_W'(DEPTH);
  logic drn_ready = 1'b0;
  logic drn_valid;
  logic [REC_W-1:0] drn_data;
  logic halt_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [REC_W-1:0] mq[$];
  int  mgap = 0;
  bit  mhalt = 1'b0;

  always #10 clk = ~clk;

  bus_trace_capture #(.DEPTH(DEPTH), .DELTA_W(DELTA_W)) dut (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_write(snp_write), .snp_src(snp_src), .cfg_filter_en(cfg_filter_en),
    .cfg_match(cfg_match), .cfg_mask(cfg_mask), .cfg_restart(cfg_restart),
    .cfg_halt_thr(cfg_halt_thr), .drn_valid(drn_valid), .drn_ready(drn_ready),
    .drn_data(drn_data), .halt_irq(halt_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: advance the model with the inputs held across the edge,
  // then compare all outputs at the following falling edge.
  task automatic tick();
    int cnt = mq.size();
    logic [35:0] attr = {snp_addr, snp_write, snp_src};
    bit pop = (cnt != 0) && drn_ready;
    bit drop = cfg_filter_en && (((attr ^ cfg_match) & cfg_mask) == 36'd0);
    bit store = snp_valid && !drop && (cnt < DEPTH);
    if (pop) void'(mq.pop_front());
    if (store) mq.push_back({attr, DELTA_W'(mgap)});
    if (store || (snp_valid && drop && cfg_restart)) mgap = 1;
    else if (mgap < GMAX) mgap++;
    cnt = mq.size();
    if (mhalt) mhalt = (cnt != 0);
    else mhalt = (cnt != 0) && (cnt >= int'(cfg_halt_thr));
    @(posedge clk);
    @(negedge clk);
    check(drn_valid == (mq.size() != 0), "R7 drain valid", 64'(drn_valid), 64'(mq.size() != 0));
    if (mq.size() != 0)
      check(drn_data == mq[0], "R2/R3 head record", 64'(drn_data), 64'(mq[0]));
    check(halt_irq == mhalt, "R9/R10 halt", 64'(halt_irq), 64'(mhalt));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic txn(input logic [31:0] a, input logic w, input logic [2:0] s);
    snp_valid = 1'b1; snp_addr = a; snp_write = w; snp_src = s;
    tick();
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty queue and no halt out of reset
    check(!drn_valid, "R1 reset valid", 64'(drn_valid), 64'd0);
    check(!halt_irq, "R1 reset halt", 64'(halt_irq), 64'd0);

    // R2 R3: each originator, gaps of different lengths, held by back-pressure
    txn(32'h0000_1001, 1'b0, 3'd0);
    idle(3);
    txn(32'hDEAD_BEEF, 1'b1, 3'd3);
    txn(32'h8000_0004, 1'b0, 3'd4);
    txn(32'h0000_2000, 1'b1, 3'd1);
    idle(2);
    txn(32'h0000_3000, 1'b0, 3'd2);
    check(drn_data[REC_W-1 -: 32] == 32'h0000_1001, "R2 head address",
          64'(drn_data[REC_W-1 -: 32]), 64'h1001);
    // R7: drain in order
    drn_ready = 1'b1;
    idle(6);

    // R5: drop I/O transactions; no restart so delta spans the dropped one
    cfg_filter_en = 1'b1;
    cfg_match = 36'h4;
    cfg_mask  = 36'h7;
    txn(32'h0000_4000, 1'b0, 3'd4);
    idle(2);
    txn(32'h0000_5000, 1'b0, 3'd1);
    idle(1);
    // R6: restart on drop
    cfg_restart = 1'b1;
    txn(32'h0000_6000, 1'b1, 3'd4);
    idle(2);
    txn(32'h0000_7000, 1'b0, 3'd2);
    // R5: address-field match, writes only
    cfg_match = {32'hF000_0000, 1'b1, 3'd0};
    cfg_mask  = {32'hF000_0000, 1'b1, 3'd0};
    txn(32'hF123_0000, 1'b1, 3'd0);
    txn(32'hF123_0000, 1'b0, 3'd0);
    txn(32'h0123_0000, 1'b1, 3'd3);
    idle(3);
    cfg_filter_en = 1'b0;
    cfg_restart = 1'b0;

    // R4: saturation after a long gap
    drn_ready = 1'b0;
    idle(300);
    txn(32'h0000_8000, 1'b0, 3'd0);
    check(drn_data[DELTA_W-1:0] == DELTA_W'(GMAX), "R4 saturated delta",
          64'(drn_data[DELTA_W-1:0]), 64'(GMAX));
    drn_ready = 1'b1;
    idle(2);

    // R9 R10 R8: fill past threshold into full, lose extras, drain slowly
    drn_ready = 1'b0;
    cfg_halt_thr = CNT_W'(5);
    for (int i = 0; i < 10; i++) txn(32'h1000_0000 + i * 16, i[0], 3'(i % 5));
    check(halt_irq, "R9 halt at threshold", 64'(halt_irq), 64'd1);
    // R8: full with a simultaneous drain still loses the arrival
    drn_ready = 1'b1;
    txn(32'h2000_0000, 1'b1, 3'd2);
    drn_ready = 1'b0;
    idle(1);
    drn_ready = 1'b1;
    idle(3);
    check(halt_irq, "R10 halt held below threshold", 64'(halt_irq), 64'd1);
    txn(32'h3000_0000, 1'b0, 3'd1);
    idle(8);
    check(!halt_irq, "R10 halt released when empty", 64'(halt_irq), 64'd0);

    // R9: threshold zero still needs a record
    cfg_halt_thr = '0;
    idle(2);
    drn_ready = 1'b0;
    txn(32'h4000_0000, 1'b0, 3'd3);
    drn_ready = 1'b1;
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule